// File: doc/BRIEF.md
# Single-Wire Pulse-Width Frame Receiver

This block listens to one open-drain wire that idles high through a pull-up. Both the sender and the receiver can only pull the wire low. The block passes the wire through a two-flop synchronizer and measures, in clock cycles, how long each low and each high level lasts. It sorts every interval into a class by length. A bit spans one low followed by one high. Its value follows from which of the two is the long one, and it is fixed at the falling edge that closes the high.

Bits are gathered most significant first. Each finished byte appears on a byte output for one cycle, together with its position in the frame. The number of bytes to expect comes in on an input. After the last byte, a short low pulse marks the end of the frame. Long gaps, long lows, very short pulses and illegal bit shapes are recognised from interval lengths alone. They are reported on single-cycle error strobes and a bus-reset level. All thresholds are parameters in clock cycles.

Top module: `swb_rx`

## Requirements
- R1: After reset, every strobe output is low, `bus_rst` is low, `byte_idx` is 0, and the first falling edge of the line starts a frame.
- R2: In idle, a falling edge starts a frame and pulses `frame_start`. `err_tsep` pulses with it when the preceding high lasted fewer than SEP_CYC cycles. A gap of exactly SEP_CYC raises no flag.
- R3: An interval of d cycles is classed as short when d < MID_CYC and long when MID_CYC <= d < LONG_MAX. `err_band` pulses when SHORT_MAX <= d < LONG_MIN. This happens for a low at its closing rising edge and for a high at its closing falling edge.
- R4: A long low followed by a short high decodes as 0. A short low followed by a long high decodes as 1. The bit is taken at the falling edge that ends the high.
- R5: A low and a high of the same class form a bit error. `err_bit` pulses, no byte is emitted for that frame, and the block waits for a separator.
- R6: Bits fill a byte MSB first. On the eighth bit, `byte_valid` pulses for one cycle with `byte_data`. `byte_idx` is 0 for the first byte of a frame and rises by one per byte.
- R7: After byte number `frame_len`-1, a low of at most TERM_CYC cycles that returns high pulses `frame_end`. A low that reaches TERM_CYC+1 cycles enters bus reset instead.
- R8: Inside a frame, a high lasting LONG_MAX cycles pulses `frame_drop` and returns to idle, discarding the partial frame.
- R9: Inside a frame, a low lasting LONG_MAX cycles raises `bus_rst`.
- R10: `bus_rst` falls only at a rising edge that ends a low of at least RST_CYC cycles. A shorter low leaves it set.
- R11: With `glitch_en` high, an interval shorter than GLITCH_CYC pulses `err_glitch` and enters separator wait. The exception is while in bus reset. With `glitch_en` low, `err_glitch` never pulses.
- R12: In separator wait, only a falling edge after a high longer than SEP_CYC cycles starts a frame. A gap of exactly SEP_CYC does not.
- R13: The interval counter saturates instead of wrapping, so an idle time far beyond the counter range still counts as a valid gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | 1 | Asynchronous wire level |
| glitch_en | input | 1 | Enables glitch detection |
| frame_len | input | IDX_W | Bytes expected in the frame (1 or more) |
| byte_valid | output | 1 | One-cycle strobe for a finished byte |
| byte_data | output | 8 | Received byte |
| byte_idx | output | IDX_W | Position of the byte in the frame |
| frame_start | output | 1 | Frame began |
| frame_end | output | 1 | Termination pulse seen |
| frame_drop | output | 1 | Partial frame dropped on a long high |
| bus_rst | output | 1 | Bus reset in progress |
| err_tsep | output | 1 | Idle gap before frame too short |
| err_band | output | 1 | Interval inside a guard band |
| err_bit | output | 1 | Illegal low/high combination |
| err_glitch | output | 1 | Interval below the glitch limit |

## Verification
The hardest states to reach are the recovery paths. These are separator wait after a glitch or a bit error, and bus reset entered mid-frame that must then ignore a low that is too short. Each one needs a precisely timed run of lows and highs before a valid frame can follow. The bench scales every threshold down to a few dozen cycles. It drives the wire in whole-cycle steps from tasks, so interval lengths land exactly on each band edge. Each error path is followed by a normal frame whose bytes must come through intact.

// File: rtl/swb_pkg.sv
`timescale 1ns/1ps
package swb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_TERM,
    ST_SEP,
    ST_RST
  } rx_state_t;

  // class of the interval that is currently running / just ended
  typedef struct packed {
    logic glitch;  // below glitch limit
    logic guard;   // inside one of the two guard bands
    logic lng;     // long side of the short/long split
  } iv_class_t;

endpackage

// File: rtl/swb_sync.sv
`timescale 1ns/1ps
module swb_sync (
  input  logic clk,
  input  logic rst,
  input  logic bus_in,
  output logic lvl_q,
  output logic rise,
  output logic fall
);

  logic [1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta  <= 2'b11;
      lvl_q <= 1'b1;
    end else begin
      meta  <= {meta[0], bus_in};
      lvl_q <= meta[1];
    end
  end

  assign rise = meta[1] & ~lvl_q;
  assign fall = ~meta[1] & lvl_q;

endmodule

// File: rtl/swb_timer.sv
`timescale 1ns/1ps
module swb_timer #(
  parameter int CNT_W      = 15,
  parameter int GLITCH_CYC = 20,
  parameter int SHORT_MAX  = 260,
  parameter int MID_CYC    = 320,
  parameter int LONG_MIN   = 465
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  edge_i,
  output logic [CNT_W-1:0]      cnt,
  output swb_pkg::iv_class_t    cls
);

  localparam logic [CNT_W-1:0] K_SAT  = '1;
  localparam logic [CNT_W-1:0] K_GL   = CNT_W'(GLITCH_CYC);
  localparam logic [CNT_W-1:0] K_SM   = CNT_W'(SHORT_MAX);
  localparam logic [CNT_W-1:0] K_MID  = CNT_W'(MID_CYC);
  localparam logic [CNT_W-1:0] K_LMIN = CNT_W'(LONG_MIN);

  // cnt = cycles since the last level change; saturates
  always_ff @(posedge clk) begin
    if (rst)              cnt <= K_SAT;
    else if (edge_i)      cnt <= CNT_W'(1);
    else if (cnt != K_SAT) cnt <= cnt + 1'b1;
  end

  always_comb begin
    cls.glitch = (cnt < K_GL);
    cls.guard  = (cnt >= K_SM) && (cnt < K_LMIN);
    cls.lng    = (cnt >= K_MID);
  end

  // R13: between level changes the count never goes backwards (no wrap)
  a_r13_no_wrap: assert property (@(posedge clk) disable iff (rst)
    !edge_i |=> cnt >= $past(cnt));

endmodule

// File: rtl/swb_fsm.sv
`timescale 1ns/1ps
module swb_fsm #(
  parameter int CNT_W    = 15,
  parameter int IDX_W    = 6,
  parameter int LONG_MAX = 12685,
  parameter int SEP_CYC  = 12800,
  parameter int TERM_CYC = 5000,
  parameter int RST_CYC  = 20000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lvl_q,
  input  logic               rise,
  input  logic               fall,
  input  logic [CNT_W-1:0]   cnt,
  input  swb_pkg::iv_class_t cls,
  input  logic               glitch_en,
  input  logic [IDX_W-1:0]   frame_len,
  output logic               byte_valid,
  output logic [7:0]         byte_data,
  output logic [IDX_W-1:0]   byte_idx,
  output logic               frame_start,
  output logic               frame_end,
  output logic               frame_drop,
  output logic               bus_rst,
  output logic               err_tsep,
  output logic               err_band,
  output logic               err_bit,
  output logic               err_glitch
);
  import swb_pkg::*;

  localparam logic [CNT_W-1:0] K_LMAX = CNT_W'(LONG_MAX);
  localparam logic [CNT_W-1:0] K_SEP  = CNT_W'(SEP_CYC);
  localparam logic [CNT_W-1:0] K_TERM = CNT_W'(TERM_CYC);
  localparam logic [CNT_W-1:0] K_RST  = CNT_W'(RST_CYC);

  rx_state_t        state;
  logic [2:0]       bit_cnt;
  logic [7:0]       sr;
  logic [IDX_W-1:0] idx;
  logic             low_long;

  logic       bit_v, dec_ok, last_byte;
  logic [7:0] nxt_byte;

  always_comb begin
    bit_v     = ~low_long;
    dec_ok    = (low_long != cls.lng);
    nxt_byte  = {sr[6:0], bit_v};
    last_byte = (idx == IDX_W'(frame_len - 1'b1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      bit_cnt     <= '0;
      sr          <= '0;
      idx         <= '0;
      low_long    <= 1'b0;
      byte_valid  <= 1'b0;
      byte_data   <= '0;
      byte_idx    <= '0;
      frame_start <= 1'b0;
      frame_end   <= 1'b0;
      frame_drop  <= 1'b0;
      err_tsep    <= 1'b0;
      err_band    <= 1'b0;
      err_bit     <= 1'b0;
      err_glitch  <= 1'b0;
    end else begin
      byte_valid  <= 1'b0;
      frame_start <= 1'b0;
      frame_end   <= 1'b0;
      frame_drop  <= 1'b0;
      err_tsep    <= 1'b0;
      err_band    <= 1'b0;
      err_bit     <= 1'b0;
      err_glitch  <= 1'b0;
      if ((rise || fall) && glitch_en && cls.glitch && state != ST_RST) begin
        err_glitch <= 1'b1;
        state      <= ST_SEP;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (fall) begin
              frame_start <= 1'b1;
              err_tsep    <= (cnt < K_SEP);
              state       <= ST_RX;
              bit_cnt     <= '0;
              idx         <= '0;
            end
          end
          ST_SEP: begin
            if (fall && cnt > K_SEP) begin
              frame_start <= 1'b1;
              state       <= ST_RX;
              bit_cnt     <= '0;
              idx         <= '0;
            end
          end
          ST_RX: begin
            if (cnt >= K_LMAX) begin
              if (!lvl_q) state <= ST_RST;
              else begin
                frame_drop <= 1'b1;
                state      <= ST_IDLE;
              end
            end else if (rise) begin
              low_long <= cls.lng;
              err_band <= cls.guard;
            end else if (fall) begin
              err_band <= cls.guard;
              if (!dec_ok) begin
                err_bit <= 1'b1;
                state   <= ST_SEP;
              end else begin
                sr      <= nxt_byte;
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                  byte_valid <= 1'b1;
                  byte_data  <= nxt_byte;
                  byte_idx   <= idx;
                  idx        <= idx + 1'b1;
                  if (last_byte) state <= ST_TERM;
                end
              end
            end
          end
          ST_TERM: begin
            if (!lvl_q && cnt > K_TERM) state <= ST_RST;
            else if (rise) begin
              frame_end <= 1'b1;
              state     <= ST_IDLE;
            end
          end
          ST_RST: begin
            if (rise && cnt >= K_RST) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign bus_rst = (state == ST_RST);

  a_r2_start_on_fall: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> $past(fall));
  a_r6_byte_on_fall: assert property (@(posedge clk) disable iff (rst)
    byte_valid |-> $past(fall));
  a_r7_end_on_rise: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> $past(rise));
  a_r8_frame_events_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({frame_start, frame_end, frame_drop}));
  a_r9_rst_only_from_low: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_rst) |-> !$past(lvl_q));
  a_r10_rst_exit_long_low: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_rst) |-> ($past(rise) && $past(cnt) >= K_RST));
  a_r11_glitch_needs_enable: assert property (@(posedge clk) disable iff (rst)
    err_glitch |-> $past(glitch_en));

endmodule

// File: rtl/swb_rx.sv
`timescale 1ns/1ps
module swb_rx #(
  parameter int IDX_W      = 6,
  parameter int GLITCH_CYC = 20,
  parameter int SHORT_MAX  = 260,
  parameter int MID_CYC    = 320,
  parameter int LONG_MIN   = 465,
  parameter int LONG_MAX   = 12685,
  parameter int SEP_CYC    = 12800,
  parameter int TERM_CYC   = 5000,
  parameter int RST_CYC    = 20000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_in,
  input  logic             glitch_en,
  input  logic [IDX_W-1:0] frame_len,
  output logic             byte_valid,
  output logic [7:0]       byte_data,
  output logic [IDX_W-1:0] byte_idx,
  output logic             frame_start,
  output logic             frame_end,
  output logic             frame_drop,
  output logic             bus_rst,
  output logic             err_tsep,
  output logic             err_band,
  output logic             err_bit,
  output logic             err_glitch
);

  localparam int CNT_W = $clog2(RST_CYC + 2);

  logic               lvl_q, rise, fall;
  logic [CNT_W-1:0]   cnt;
  swb_pkg::iv_class_t cls;

  swb_sync u_sync (
    .clk    (clk),
    .rst    (rst),
    .bus_in (bus_in),
    .lvl_q  (lvl_q),
    .rise   (rise),
    .fall   (fall)
  );

  swb_timer #(
    .CNT_W      (CNT_W),
    .GLITCH_CYC (GLITCH_CYC),
    .SHORT_MAX  (SHORT_MAX),
    .MID_CYC    (MID_CYC),
    .LONG_MIN   (LONG_MIN)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .edge_i (rise | fall),
    .cnt    (cnt),
    .cls    (cls)
  );

  swb_fsm #(
    .CNT_W    (CNT_W),
    .IDX_W    (IDX_W),
    .LONG_MAX (LONG_MAX),
    .SEP_CYC  (SEP_CYC),
    .TERM_CYC (TERM_CYC),
    .RST_CYC  (RST_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .lvl_q       (lvl_q),
    .rise        (rise),
    .fall        (fall),
    .cnt         (cnt),
    .cls         (cls),
    .glitch_en   (glitch_en),
    .frame_len   (frame_len),
    .byte_valid  (byte_valid),
    .byte_data   (byte_data),
    .byte_idx    (byte_idx),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .frame_drop  (frame_drop),
    .bus_rst     (bus_rst),
    .err_tsep    (err_tsep),
    .err_band    (err_band),
    .err_bit     (err_bit),
    .err_glitch  (err_glitch)
  );

endmodule

// File: tb/swb_rx_tb_top.sv
`timescale 1ns/1ps
module swb_rx_tb_top;

  localparam int IDX_W  = 6;
  localparam int GL     = 3;
  localparam int SMAX   = 8;
  localparam int MID    = 10;
  localparam int LMIN   = 14;
  localparam int LMAX   = 60;
  localparam int SEP    = 64;
  localparam int TERM   = 30;
  localparam int RSTC   = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_in = 1'b1;
  logic glitch_en = 1'b1;
  logic [IDX_W-1:0] frame_len = 6'd1;

  logic             byte_valid, frame_start, frame_end, frame_drop, bus_rst;
  logic             err_tsep, err_band, err_bit, err_glitch;
  logic [7:0]       byte_data;
  logic [IDX_W-1:0] byte_idx;

  swb_rx #(
    .IDX_W(IDX_W), .GLITCH_CYC(GL), .SHORT_MAX(SMAX), .MID_CYC(MID),
    .LONG_MIN(LMIN), .LONG_MAX(LMAX), .SEP_CYC(SEP), .TERM_CYC(TERM),
    .RST_CYC(RSTC)
  ) dut_i (
    .clk(clk), .rst(rst), .bus_in(bus_in), .glitch_en(glitch_en),
    .frame_len(frame_len), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_idx(byte_idx), .frame_start(frame_start), .frame_end(frame_end),
    .frame_drop(frame_drop), .bus_rst(bus_rst), .err_tsep(err_tsep),
    .err_band(err_band), .err_bit(err_bit), .err_glitch(err_glitch)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int n_start, n_end, n_drop, n_tsep, n_band, n_bit, n_glitch, got_n;
  logic [7:0] got_data [0:63];
  int         got_idx  [0:63];
  logic [7:0] tx [0:15];

  always @(negedge clk) begin
    if (!rst) begin
      if (byte_valid) begin
        if (got_n < 64) begin
          got_data[got_n] = byte_data;
          got_idx[got_n]  = int'(byte_idx);
        end
        got_n++;
      end
      if (frame_start) n_start++;
      if (frame_end)   n_end++;
      if (frame_drop)  n_drop++;
      if (err_tsep)    n_tsep++;
      if (err_band)    n_band++;
      if (err_bit)     n_bit++;
      if (err_glitch)  n_glitch++;
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_ev();
    n_start = 0; n_end = 0; n_drop = 0; n_tsep = 0;
    n_band = 0; n_bit = 0; n_glitch = 0; got_n = 0;
  endtask

  function automatic int rs();
    return 3 + int'($urandom % 5);
  endfunction
  function automatic int rl();
    return LMIN + int'($urandom % 27);
  endfunction

  task automatic hold(input logic lv, input int n);
    bus_in = lv;
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_t(input int lo, input int hi);
    hold(1'b0, lo);
    hold(1'b1, hi);
  endtask

  task automatic send_byte(input logic [7:0] d);
    for (int b = 7; b >= 0; b--) begin
      if (d[b]) bit_t(rs(), rl());
      else      bit_t(rl(), rs());
    end
  endtask

  task automatic send_byte_fix(input logic [7:0] d, input int s, input int l);
    for (int b = 7; b >= 0; b--) begin
      if (d[b]) bit_t(s, l);
      else      bit_t(l, s);
    end
  endtask

  task automatic term(input int t);
    hold(1'b0, t);
    bus_in = 1'b1;
  endtask

  task automatic frame(input int gap, input int n, input int t);
    hold(1'b1, gap);
    for (int i = 0; i < n; i++) send_byte(tx[i]);
    term(t);
  endtask

  task automatic check_bytes(input string req, input int n);
    chk(req, "byte count", got_n, n);
    for (int i = 0; i < n && i < got_n; i++) begin
      chk(req, "byte data", int'(got_data[i]), int'(tx[i]));
      chk(req, "byte index", got_idx[i], i);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    clear_ev();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1", "strobes", int'({byte_valid, frame_start, frame_end, frame_drop,
        err_tsep, err_band, err_bit, err_glitch}), 0);
    chk("R1", "bus_rst", int'(bus_rst), 0);
    chk("R1", "byte_idx", int'(byte_idx), 0);

    // R4 R6 R7 random frames with clean timing
    for (int f = 0; f < 20; f++) begin
      int len;
      len = 1 + int'($urandom % 4);
      frame_len = IDX_W'(len);
      for (int i = 0; i < len; i++) tx[i] = 8'($urandom);
      clear_ev();
      frame(70 + int'($urandom % 20), len, 3 + int'($urandom % 28));
      hold(1'b1, 6);
      check_bytes("R6", len);
      chk("R2", "frame_start count", n_start, 1);
      chk("R7", "frame_end count", n_end, 1);
      chk("R3", "band flags", n_band, 0);
      chk("R2", "tsep flags", n_tsep, 0);
    end

    // R3 guard bands still decode, and flag
    frame_len = 6'd1;
    clear_ev();
    hold(1'b1, 70);
    bit_t(9, 20);
    bit_t(12, 5);
    bit_t(5, 20); bit_t(5, 20); bit_t(20, 5); bit_t(20, 5); bit_t(5, 20); bit_t(5, 20);
    term(10);
    hold(1'b1, 6);
    chk("R3", "guard byte count", got_n, 1);
    chk("R3", "guard byte", int'(got_data[0]), 8'hB3);
    chk("R3", "guard flags", n_band, 2);

    // R3 R4 clean band edges (short 7, long 14 and 59)
    clear_ev();
    tx[0] = 8'h5A;
    hold(1'b1, 70);
    send_byte_fix(8'h5A, 7, 14);
    term(10);
    hold(1'b1, 70);
    send_byte_fix(8'h5A, 7, 59);
    term(10);
    hold(1'b1, 6);
    chk("R4", "edge byte count", got_n, 2);
    chk("R4", "edge byte 0", int'(got_data[0]), 8'h5A);
    chk("R4", "edge byte 1", int'(got_data[1]), 8'h5A);
    chk("R3", "edge band flags", n_band, 0);

    // R2 separator gap boundary in idle
    clear_ev();
    tx[0] = 8'h3C;
    frame(80, 1, 10);
    frame(64, 1, 10);
    frame(63, 1, 10);
    hold(1'b1, 6);
    chk("R2", "boundary starts", n_start, 3);
    chk("R2", "boundary tsep", n_tsep, 1);
    chk("R7", "boundary ends", n_end, 3);

    // R5 bit error, R12 resync boundary
    clear_ev();
    tx[0] = 8'hC7;
    hold(1'b1, 80);
    bit_t(20, 20);
    hold(1'b0, 5);
    hold(1'b1, 64);
    hold(1'b0, 5);
    frame(65, 1, 10);
    hold(1'b1, 6);
    chk("R5", "bit errors", n_bit, 1);
    chk("R12", "resync starts", n_start, 2);
    chk("R12", "resync ends", n_end, 1);
    check_bytes("R12", 1);

    // R11 glitch enabled
    clear_ev();
    tx[0] = 8'h69;
    hold(1'b1, 80);
    hold(1'b0, 10);
    hold(1'b1, 2);
    hold(1'b0, 10);
    frame(70, 1, 10);
    hold(1'b1, 6);
    chk("R11", "glitch flags", n_glitch, 1);
    chk("R11", "starts after glitch", n_start, 2);
    check_bytes("R11", 1);

    // R11 glitch disabled, R8 drop on long high
    glitch_en = 1'b0;
    clear_ev();
    hold(1'b1, 80);
    hold(1'b0, 10);
    hold(1'b1, 2);
    hold(1'b0, 10);
    hold(1'b1, 70);
    chk("R11", "glitch flags when off", n_glitch, 0);
    chk("R8", "drop count", n_drop, 1);
    chk("R3", "band flags on 10-cycle lows", n_band, 2);
    chk("R8", "no frame_end", n_end, 0);
    glitch_en = 1'b1;

    // R8 drop after one full byte of two
    frame_len = 6'd2;
    clear_ev();
    tx[0] = 8'h81;
    hold(1'b1, 10);
    send_byte(8'h81);
    hold(1'b0, 5);
    hold(1'b1, 70);
    check_bytes("R8", 1);
    chk("R8", "drop count", n_drop, 1);
    chk("R8", "no frame_end", n_end, 0);

    // R9 R10 bus reset inside frame
    frame_len = 6'd1;
    clear_ev();
    hold(1'b1, 80);
    bit_t(20, 5);
    hold(1'b0, 80);
    chk("R9", "bus_rst after long low", int'(bus_rst), 1);
    hold(1'b1, 20);
    chk("R10", "bus_rst kept after short low", int'(bus_rst), 1);
    hold(1'b0, 120);
    hold(1'b1, 6);
    chk("R10", "bus_rst cleared", int'(bus_rst), 0);
    tx[0] = 8'hE1;
    frame(70, 1, 10);
    hold(1'b1, 6);
    chk("R10", "frame after reset", n_end, 1);
    check_bytes("R10", 1);

    // R7 termination too long, then exact reset length
    clear_ev();
    tx[0] = 8'h0F;
    frame(70, 1, 40);
    hold(1'b1, 10);
    chk("R7", "long term bus_rst", int'(bus_rst), 1);
    chk("R7", "long term no end", n_end, 0);
    hold(1'b0, 100);
    hold(1'b1, 6);
    chk("R10", "exact reset length clears", int'(bus_rst), 0);
    clear_ev();
    frame(70, 1, 30);
    hold(1'b1, 6);
    chk("R7", "term at limit ends", n_end, 1);
    chk("R7", "term at limit bus_rst", int'(bus_rst), 0);

    // R13 saturation over a long idle
    clear_ev();
    tx[0] = 8'h96;
    frame(400, 1, 10);
    hold(1'b1, 6);
    chk("R13", "tsep after long idle", n_tsep, 0);
    chk("R13", "frame after long idle", n_end, 1);
    check_bytes("R13", 1);

    done = 1'b1;
    report();
  end

endmodule